// File: doc/BRIEF.md
# Variable-Length Instruction Aligner

This block sits between instruction fetch and decode. Fetch delivers 64-bit words of raw instruction bytes. The block cuts that byte stream into complete instructions that are 2, 3 or 8 bytes long, and hands the decoder one instruction per cycle. Each instruction is presented left-aligned on a 64-bit bus, together with its length in bytes. The stream holds no separate boundary information. The length of each instruction is decoded from a two-bit format code in its first byte, so instructions of any length can follow one another freely.

A 16-byte staging buffer collects fetched bytes. When the buffer does not yet hold the whole of the next instruction, the output is held off, and fetch stays ready for as long as there is room. A redirect, for example after a taken branch, discards everything in the buffer in the same cycle. The next accepted fetch word is then read from a byte offset that arrives with the redirect, so a branch target need not sit on a word boundary. If fetch keeps supplying words and the decoder is always ready, the block emits an instruction every cycle with no gaps, whatever mix of lengths arrives.

Top module: `ilen_aligner`

## Requirements
- R1: The length of an instruction comes from bits [7:6] of its first byte. Code 00 selects 3 bytes, 01 selects 2 bytes, 10 selects 8 bytes and 11 selects 2 bytes. out_len reports that length as a byte count.
- R2: Bytes flow in stream order. The first byte of a fetch word is fetch_data[63:56]. The first byte of an emitted instruction appears on out_insn[63:56], and the bytes that follow it appear on successively lower bytes of the bus.
- R3: While out_valid is high, every byte of out_insn beyond out_len is zero.
- R4: out_valid is high exactly when no redirect is present and the buffer holds at least as many bytes as the length of the next instruction.
- R5: fetch_ready is high exactly when no redirect is present and the buffer, after this cycle's output is removed, holds 8 bytes or fewer. A word is taken when fetch_valid and fetch_ready are both high.
- R6: If fetch words arrive every cycle and out_ready stays high, out_valid stays high on every cycle from the first complete instruction onward, for any mix of lengths.
- R7: When out_valid is high and out_ready is low, nothing is consumed. The same instruction is presented on the next cycle unless a redirect occurs.
- R8: In a cycle where redir_valid is high, out_valid and fetch_ready are both low. The buffer is emptied and any fetch word presented in that cycle is dropped.
- R9: After a redirect, the first word accepted contributes only its bytes from position redir_offset onward. Later words contribute all 8 bytes.
- R10: An instruction with format code 11 is emitted with out_illegal high and consumes 2 bytes. out_illegal is low for every other code.
- R11: After reset the buffer is empty, out_valid is low and fetch_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | A fetch word is presented |
| fetch_data | input | 64 | Fetch word, first byte in the top byte |
| fetch_ready | output | 1 | The block takes the presented word this cycle |
| redir_valid | input | 1 | Flush request that starts a new stream |
| redir_offset | input | 3 | First valid byte of the next accepted word |
| out_valid | output | 1 | A complete instruction is presented |
| out_ready | input | 1 | The decoder takes the instruction |
| out_insn | output | 64 | Instruction, left-aligned and zero padded |
| out_len | output | 4 | Instruction length in bytes |
| out_illegal | output | 1 | The format code is the reserved value |

## Verification
An error in the buffer fill count or in the shift position shows at the ports in the very next cycle. Bytes move on the instruction bus, out_len is decoded from the wrong byte, or out_valid or fetch_ready switches at a different moment from a byte-queue model. Because every later boundary depends on earlier lengths, a single misplaced byte corrupts all instructions that follow, until the next redirect. The bench therefore compares every output on every clock against a model that keeps the buffer as a plain byte queue. It mixes random lengths, backpressure from the decoder, gaps in fetch and redirects with random offsets.

// File: rtl/ilen_aligner.sv
module ilen_aligner #(
  parameter int FETCH_BYTES = 8,
  parameter int BUF_BYTES   = 16,
  parameter int OUT_BYTES   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fetch_valid,
  input  logic [8*FETCH_BYTES-1:0]   fetch_data,
  output logic                       fetch_ready,
  input  logic                       redir_valid,
  input  logic [$clog2(FETCH_BYTES)-1:0] redir_offset,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [8*OUT_BYTES-1:0]     out_insn,
  output logic [$clog2(OUT_BYTES+1)-1:0] out_len,
  output logic                       out_illegal
);
  localparam int CW = $clog2(BUF_BYTES + 1);
  localparam int AW = $clog2(BUF_BYTES);
  localparam int OW = $clog2(OUT_BYTES + 1);
  localparam int SW = $clog2(FETCH_BYTES);

  logic [7:0]    sb  [BUF_BYTES];
  logic [7:0]    nxt [BUF_BYTES];
  logic [CW-1:0] fill, fill_d, len, pop, rem;
  logic [SW-1:0] skip;
  logic [1:0]    lead;
  logic          take;

  assign lead = sb[0][7:6];

  always_comb begin
    unique case (lead)
      2'b00:   len = CW'(3);
      2'b01:   len = CW'(2);
      2'b10:   len = CW'(8);
      default: len = CW'(2);
    endcase
  end

  assign out_valid   = !redir_valid && (fill >= len);
  assign pop         = (out_valid && out_ready) ? len : '0;
  assign rem         = fill - pop;
  assign fetch_ready = !redir_valid && (rem <= CW'(FETCH_BYTES));
  assign take        = fetch_valid && fetch_ready;
  assign fill_d      = rem + (take ? (CW'(FETCH_BYTES) - CW'(skip)) : '0);
  assign out_len     = OW'(len);
  assign out_illegal = out_valid && (lead == 2'b11);

  always_comb begin
    for (int i = 0; i < BUF_BYTES; i++) begin
      int src;
      int k;
      src = i + int'(pop);
      k   = i - int'(rem) + int'(skip);
      if (src < int'(fill))
        nxt[i] = sb[src[AW-1:0]];
      else if (take && k < FETCH_BYTES)
        nxt[i] = fetch_data[8*(FETCH_BYTES-1-k) +: 8];
      else
        nxt[i] = 8'h00;
    end
  end

  always_comb begin
    for (int j = 0; j < OUT_BYTES; j++)
      out_insn[8*(OUT_BYTES-1-j) +: 8] = (j < int'(len)) ? sb[j] : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill <= '0;
      skip <= '0;
      for (int i = 0; i < BUF_BYTES; i++) sb[i] <= 8'h00;
    end else if (redir_valid) begin
      fill <= '0;
      skip <= redir_offset;
      for (int i = 0; i < BUF_BYTES; i++) sb[i] <= 8'h00;
    end else begin
      fill <= fill_d;
      if (take) skip <= '0;
      for (int i = 0; i < BUF_BYTES; i++) sb[i] <= nxt[i];
    end
  end

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(BUF_BYTES));

  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> (fill == '0));

  a_r1_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_len == OW'(2) || out_len == OW'(3) || out_len == OW'(8)));

  a_r3_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_len == OW'(2)) |-> (out_insn[8*OUT_BYTES-17:0] == '0));

  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (redir_valid || ($stable(out_insn) && out_valid)));

  a_r9_skip_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !redir_valid) |=> (skip == '0 || $past(redir_valid)));

  a_r10_illegal_code: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> (out_insn[8*OUT_BYTES-1 -: 2] == 2'b11 && out_valid));
endmodule

// File: tb/test_ilen_aligner.sv
module test_ilen_aligner;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [63:0] fetch_data = '0;
  logic        fetch_ready;
  logic        redir_valid = 1'b0;
  logic [2:0]  redir_offset = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_insn;
  logic [3:0]  out_len;
  logic        out_illegal;

  int checks = 0;
  int fails  = 0;
  logic [7:0] prog[$];
  logic [7:0] mq[$];
  int fp = 0;
  int skip = 0;
  logic        prev_hold = 1'b0;
  logic [63:0] prev_insn = '0;
  logic        want_first = 1'b0;
  logic [7:0]  first_byte = '0;
  int gaps = 0;

  always #10 clk = ~clk;

  ilen_aligner i_ilen_aligner (
    .clk(clk), .rst_n(rst_n),
    .fetch_valid(fetch_valid), .fetch_data(fetch_data), .fetch_ready(fetch_ready),
    .redir_valid(redir_valid), .redir_offset(redir_offset),
    .out_valid(out_valid), .out_ready(out_ready), .out_insn(out_insn),
    .out_len(out_len), .out_illegal(out_illegal));

  function automatic int lenof(logic [7:0] b);
    case (b[7:6])
      2'b00:   return 3;
      2'b01:   return 2;
      2'b10:   return 8;
      default: return 2;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic add_insn(input int code_pick);
    logic [1:0] code;
    int n;
    if (code_pick < 35) code = 2'b00;
    else if (code_pick < 65) code = 2'b01;
    else if (code_pick < 90) code = 2'b10;
    else code = 2'b11;
    prog.push_back({code, 6'($urandom)});
    n = lenof({code, 6'd0});
    for (int b = 1; b < n; b++) prog.push_back(8'($urandom));
  endtask

  task automatic ensure_prog();
    while (prog.size() < fp + 16) add_insn($urandom_range(0, 99));
  endtask

  function automatic logic [63:0] word_at(int p);
    logic [63:0] w;
    for (int b = 0; b < 8; b++) w[8*(7-b) +: 8] = prog[p+b];
    return w;
  endfunction

  task automatic step(input bit fv, input bit ordy, input bit rd, input int off);
    int L, popped, sz;
    bit ev, er;
    logic [63:0] exp_insn;
    @(negedge clk);
    ensure_prog();
    fetch_valid  = fv;
    out_ready    = ordy;
    redir_valid  = rd;
    redir_offset = 3'(off);
    if (!rd) fetch_data = word_at(fp);
    #1;
    sz = mq.size();
    L  = (sz > 0) ? lenof(mq[0]) : 2;
    ev = !rd && sz >= L;
    popped = (ev && ordy) ? L : 0;
    er = !rd && (sz - popped) <= 8;
    check(out_valid == ev, "R4", 64'(out_valid), 64'(ev));
    check(fetch_ready == er, "R5", 64'(fetch_ready), 64'(er));
    if (rd) check(!out_valid && !fetch_ready, "R8", {62'd0, out_valid, fetch_ready}, 64'd0);
    if (ev) begin
      exp_insn = '0;
      for (int b = 0; b < L; b++) exp_insn[8*(7-b) +: 8] = mq[b];
      check(out_len == 4'(L), "R1", 64'(out_len), 64'(L));
      check(out_insn == exp_insn, "R2", out_insn, exp_insn);
      check(out_illegal == (mq[0][7:6] == 2'b11), "R10", 64'(out_illegal), 64'(mq[0][7:6] == 2'b11));
      if (want_first) begin
        check(out_insn[63:56] == first_byte, "R9", 64'(out_insn[63:56]), 64'(first_byte));
        want_first = 1'b0;
      end
    end else begin
      check(out_illegal == 1'b0, "R10", 64'(out_illegal), 64'd0);
    end
    if (out_valid) begin
      for (int b = 0; b < 8; b++)
        if (b >= int'(out_len)) check(out_insn[8*(7-b) +: 8] == 8'h00, "R3", 64'(out_insn[8*(7-b) +: 8]), 64'd0);
    end
    if (prev_hold && !rd) check(out_insn == prev_insn && out_valid, "R7", out_insn, prev_insn);
    prev_hold = ev && !ordy;
    prev_insn = out_insn;
    if (rd) begin
      mq.delete();
      skip = off;
      prog.delete();
      for (int b = 0; b < off; b++) prog.push_back(8'hEE);
      fp = 0;
      ensure_prog();
      first_byte = prog[off];
      want_first = 1'b1;
    end else begin
      for (int b = 0; b < popped; b++) void'(mq.pop_front());
      if (fv && er) begin
        for (int b = skip; b < 8; b++) mq.push_back(prog[fp+b]);
        fp += 8;
        skip = 0;
      end
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R11", 64'(out_valid), 64'd0);
    check(fetch_ready == 1'b1, "R11", 64'(fetch_ready), 64'd1);
    rst_n = 1'b1;
    ensure_prog();
    // R6: continuous fetch and ready decoder, no gaps after first instruction
    for (int c = 0; c < 200; c++) begin
      step(1'b1, 1'b1, 1'b0, 0);
      if (c >= 1 && !out_valid) gaps++;
    end
    check(gaps == 0, "R6", 64'(gaps), 64'd0);
    // R9: redirect with each offset then steady flow
    for (int o = 0; o < 8; o++) begin
      step(1'b1, 1'b1, 1'b1, o);
      for (int c = 0; c < 20; c++) step(1'b1, 1'b1, 1'b0, 0);
    end
    // mixed backpressure, fetch gaps and redirects
    for (int c = 0; c < 3000; c++) begin
      int r;
      r = $urandom_range(0, 99);
      step($urandom_range(0, 99) < 70, $urandom_range(0, 99) < 60, r < 3, $urandom_range(0, 7));
    end
    @(negedge clk);
    finish_run();
  end
endmodule